// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a 32-bit interval timer reached through a small word-wide register bus. Software loads a reload value, picks a prescale factor and sets two control bits, one for power and one for enable. While both are set, the count falls by one every (scale + 1) clocks. When the count runs out, the block raises a sticky flag in its control word and emits a one-cycle interrupt pulse. It then reloads the count from the reload register, or it halts at zero, depending on an auto-reload bit.

Writes to the reload and count registers are accepted while the timer runs. A reload write also sets the count. Changing the prescale factor mid-count keeps the current count, and the count then falls at the new rate. The control word is overwritten whole on every write, so software clears the flag by writing the word back with that bit at zero. Only aligned full-word accesses are legal. Any other access returns an error and leaves every register unchanged.

Top module: `core_tick_timer`

## Requirements
- R1: After reset, all four registers read 0, `irq_pulse` is 0 and `bus_err` is 0.
- R2: The count decrements only while control bit0 (power) and bit1 (enable) are both 1. With either bit at 0, the count holds its value.
- R3: The prescale factor is scale[7:0] + 1. After the control write that enables the timer, the count first drops at the (scale[7:0]+1)-th clock edge and then once every scale[7:0]+1 edges. Scale bits above bit 7 are stored and read back, but they do not affect counting.
- R4: An expiry occurs on the decrement that takes the count from 1. It sets control bit3 (flag) and drives `irq_pulse` high for the cycle after that edge.
- R5: If control bit2 (auto-reload) is 1 at expiry, the count is reloaded from the reload register and counting continues, so the next expiry follows after another reload × factor edges.
- R6: If auto-reload is 0 at expiry, the count becomes 0. With a count of 0, no further expiry happens until software writes a new value.
- R7: A write to the reload register (offset 0x4) puts the same value into the count register (offset 0xC).
- R8: A write to the count register while the timer runs takes effect at once and wins over a decrement in the same cycle.
- R9: A control write (offset 0x0) replaces bits 3:0 as written. Writing 0 to bit3 clears the flag, and writing 1 to bit3 sets it.
- R10: A write to the scale register (offset 0x8) while the timer runs keeps the current count. Later decrements follow the new factor.
- R11: An access with `bus_size` other than 2 (word), with nonzero `bus_addr[1:0]`, or with an address above 0xC raises `bus_err` in the same cycle and changes no register.
- R12: Control bits 31:4 always read 0. A read at offset 0xC returns the live count.
- R13: If a control write that clears the flag lands in the same cycle as an expiry, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: 0x0 control, 0x4 reload, 0x8 scale, 0xC count |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the registers |
| bus_err | output | 1 | Illegal access, same cycle |
| irq_pulse | output | 1 | One-cycle pulse per expiry |

## Verification
A prescaler phase that drifts, or an off-by-one in the expiry compare, moves the interrupt pulse by at least one edge. A pulse is expected within a few dozen cycles of enabling the timer, so the timing sweep exposes such a fault on the first expiry. A lost reload or a stuck flag shows on the count or control read taken in the same cycle as the pulse, and a wrong prescale factor shows again at the second expiry. Frozen, preserved or rejected state is read back through the bus right after the stimulus, before any other write can mask it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_DW  = 32;
    localparam int TMR_PW  = 8;
    localparam int TMR_NREG = 4;

    typedef enum logic [1:0] {
        RIDX_CTL = 2'd0,
        RIDX_RLD = 2'd1,
        RIDX_SCL = 2'd2,
        RIDX_CNT = 2'd3
    } reg_idx_e;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    // bit0 power, bit1 enable, bit2 auto-reload, bit3 flag
    typedef struct packed {
        logic flag;
        logic arl;
        logic en;
        logic pwr;
    } ctl_t;

    typedef struct packed {
        ctl_t              ctl;
        logic [TMR_DW-1:0] reload;
        logic [TMR_DW-1:0] scale;
        logic [TMR_DW-1:0] count;
        logic              irq;
    } tmr_state_t;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                           sel,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [1:0]                     size,
    input  logic [TMR_NREG-1:0][TMR_DW-1:0] words,
    output logic [TMR_NREG-1:0]            wr_oh,
    output logic                           err,
    output logic [TMR_DW-1:0]              rdata
);
    localparam int IDX_W = $clog2(TMR_NREG);
    localparam int TOP_B = IDX_W + 2;

    logic             bad_shape;
    logic             bad_range;
    logic [IDX_W-1:0] idx;

    assign idx       = addr[TOP_B-1:2];
    assign bad_shape = (size != SIZE_WORD) || (addr[1:0] != 2'b00);

    generate
        if (ADDR_W > TOP_B) begin : g_hi
            assign bad_range = |addr[ADDR_W-1:TOP_B];
        end else begin : g_nohi
            assign bad_range = 1'b0;
        end
    endgenerate

    assign err = sel && (bad_shape || bad_range);

    for (genvar i = 0; i < TMR_NREG; i++) begin : g_strobe
        assign wr_oh[i] = sel && we && !err && (idx == IDX_W'(i));
    end

    always_comb begin
        rdata = '0;
        if (sel && !we && !err) rdata = words[idx];
    end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] factor_m1,
    output logic             tick
);
    logic [PRE_W-1:0] phase_d, phase_q;

    always_comb begin
        tick    = run && (phase_q >= factor_m1);
        phase_d = phase_q;
        if (!run || tick) phase_d = '0;
        else              phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              irq_pulse
);
    tmr_state_t st_d, st_q;

    logic [TMR_NREG-1:0]             wr_oh;
    logic [TMR_NREG-1:0][TMR_DW-1:0] words;
    logic                            run;
    logic                            tick;
    logic                            expire;
    logic                            unused_wbits;

    assign run          = st_q.ctl.pwr && st_q.ctl.en;
    assign unused_wbits = ^bus_wdata[TMR_DW-1:4];

    always_comb begin
        words              = '0;
        words[RIDX_CTL]    = {{(TMR_DW-4){1'b0}}, st_q.ctl};
        words[RIDX_RLD]    = st_q.reload;
        words[RIDX_SCL]    = st_q.scale;
        words[RIDX_CNT]    = st_q.count;
    end

    tmr_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .sel   (bus_sel),
        .we    (bus_we),
        .addr  (bus_addr),
        .size  (bus_size),
        .words (words),
        .wr_oh (wr_oh),
        .err   (bus_err),
        .rdata (bus_rdata)
    );

    tmr_prescale #(.PRE_W(TMR_PW)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .factor_m1 (st_q.scale[TMR_PW-1:0]),
        .tick      (tick)
    );

    assign expire = tick && (st_q.count == TMR_DW'(1));

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (tick && st_q.count != '0) st_d.count = st_q.count - 1'b1;
        if (expire) st_d.count = st_q.ctl.arl ? st_q.reload : '0;

        if (wr_oh[RIDX_CTL]) st_d.ctl    = ctl_t'(bus_wdata[3:0]);
        if (wr_oh[RIDX_SCL]) st_d.scale  = bus_wdata;
        if (wr_oh[RIDX_RLD]) begin
            st_d.reload = bus_wdata;
            st_d.count  = bus_wdata;
        end
        if (wr_oh[RIDX_CNT]) st_d.count  = bus_wdata;

        if (expire) begin
            st_d.ctl.flag = 1'b1;
            st_d.irq      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pulse = st_q.irq;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_pulse,
    input logic              run,
    input logic              flag,
    input logic [31:0]       count,
    input logic [31:0]       reload,
    input logic [31:0]       scale
);
    logic wr_ok;
    assign wr_ok = bus_sel && bus_we && !bus_err;

    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_ok) |=> $stable(count));

    p_irq_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> flag);

    p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == 32'd0 && !wr_ok) |=> (count == 32'd0));

    p_reload_copies_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == ADDR_W'(4)) |=> (count == $past(bus_wdata)));

    p_err_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> ($stable(reload) && $stable(scale)));

    p_ctl_high_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !bus_err && bus_addr == '0) |-> (bus_rdata[31:4] == 28'd0));
endmodule

bind core_tick_timer tmr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_err   (bus_err),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse),
    .run       (run),
    .flag      (st_q.ctl.flag),
    .count     (st_q.count),
    .reload    (st_q.reload),
    .scale     (st_q.scale)
);

// File: tb/tb_core_tick_timer.sv
module tb_core_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [3:0] A_CTL = 4'h0, A_RLD = 4'h4, A_SCL = 4'h8, A_CNT = 4'hC;

    always #5 clk = ~clk;

    core_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_pulse(irq_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr_sz(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz,
                         output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        #1 e = bus_err;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_size = 2'd2;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        logic e;
        wr_sz(a, d, 2'd2, e);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = 2'd2;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic        e;

        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1: reset state
        rd(A_CTL, v); check("R1 ctl", v, 0);
        rd(A_RLD, v); check("R1 reload", v, 0);
        rd(A_SCL, v); check("R1 scale", v, 0);
        rd(A_CNT, v); check("R1 count", v, 0);
        check("R1 irq", {31'd0, irq_pulse}, 0);
        check("R1 err", {31'd0, bus_err}, 0);

        // R7: reload write mirrors into count
        wr(A_RLD, 32'd20);
        rd(A_CNT, v); check("R7 count mirror", v, 20);
        rd(A_RLD, v); check("R7 reload", v, 20);

        // R2: power alone / enable alone do not count
        wr(A_CTL, 32'h1); wait_n(10);
        rd(A_CNT, v); check("R2 power only", v, 20);
        wr(A_CTL, 32'h2); wait_n(10);
        rd(A_CNT, v); check("R2 enable only", v, 20);
        wr(A_CTL, 32'h3); wait_n(5);
        rd(A_CNT, v); check("R2 R12 live count", v, 15);
        wr(A_CTL, 32'h1);
        rd(A_CNT, v); wait_n(10);
        rd(A_CNT, v2); check("R2 frozen", v2, v);

        // R3 R4 R5 R6: sweep of scale, count and auto-reload
        for (int s = 0; s < 3; s++) begin
            for (int c = 1; c <= 3; c++) begin
                for (int a = 0; a < 2; a++) begin
                    int exp1, first, second, npulse;
                    exp1 = c * (s + 1);
                    first = 0; second = 0; npulse = 0;
                    wr(A_CTL, 32'h0);
                    wr(A_SCL, 32'(s) | 32'hFFFF_FF00);
                    wr(A_RLD, 32'(c));
                    wr(A_CTL, 32'h3 | (32'(a) << 2));
                    for (int k = 1; k <= 2 * exp1 + 4; k++) begin
                        @(negedge clk);
                        if (irq_pulse) begin
                            npulse++;
                            if (first == 0) begin
                                first = k;
                                rd(A_CTL, v); check("R4 flag set", v & 32'h8, 32'h8);
                                rd(A_CNT, v);
                                check(a ? "R5 reload at expiry" : "R6 zero at expiry",
                                      v, a ? 32'(c) : 0);
                            end else if (second == 0) second = k;
                        end
                    end
                    check("R3 first expiry edge", 32'(first), 32'(exp1));
                    check(a ? "R5 second expiry edge" : "R6 no second expiry",
                          32'(second), a ? 32'(2 * exp1) : 0);
                    if (!a) begin
                        rd(A_CNT, v); check("R6 count stays zero", v, 0);
                        check("R4 single pulse", 32'(npulse), 1);
                    end
                end
            end
        end

        // R9: control overwrite, flag set by write of 1, cleared by 0
        wr(A_CTL, 32'hFFFF_FFF8);
        rd(A_CTL, v); check("R9 R12 flag written 1", v, 32'h8);
        wr(A_CTL, 32'hFFFF_FFF0);
        rd(A_CTL, v); check("R9 R12 flag cleared", v, 0);

        // R8: count write while running
        wr(A_SCL, 32'd3);
        wr(A_RLD, 32'd100);
        wr(A_CTL, 32'h3);
        wait_n(6);
        wr(A_CNT, 32'd50);
        rd(A_CNT, v); check("R8 count write", v, 50);

        // R10: scale change mid-count
        wr(A_CTL, 32'h0);
        wr(A_SCL, 32'd0);
        wr(A_RLD, 32'd100);
        wr(A_CTL, 32'h3);
        wait_n(10);
        rd(A_CNT, v);
        check("R10 pre", v, 90);
        wr(A_SCL, 32'd3);
        rd(A_CNT, v2); check("R10 count kept", v2, v - 2);
        wait_n(3);
        rd(A_CNT, v2); check("R10 new rate hold", v2, v - 2);
        wait_n(1);
        rd(A_CNT, v2); check("R10 new rate step", v2, v - 3);

        // R11: illegal accesses
        wr(A_CTL, 32'h0);
        wr_sz(A_RLD, 32'd7, 2'd1, e); check("R11 err half", {31'd0, e}, 1);
        wr_sz(A_RLD + 4'd1, 32'd7, 2'd2, e); check("R11 err misaligned", {31'd0, e}, 1);
        wr_sz(A_SCL, 32'd9, 2'd0, e); check("R11 err byte", {31'd0, e}, 1);
        wr_sz(A_SCL, 32'd9, 2'd2, e); check("R11 no err word", {31'd0, e}, 0);
        rd(A_RLD, v); check("R11 reload unchanged", v, 100);
        wr_sz(A_SCL, 32'd1, 2'd1, e);
        rd(A_SCL, v); check("R11 scale unchanged", v, 9);

        // R13: flag-clearing control write collides with expiry
        wr(A_SCL, 32'd0);
        wr(A_RLD, 32'd3);
        wr(A_CTL, 32'h3);
        wait_n(1);
        wr(A_CTL, 32'h3);
        rd(A_CTL, v); check("R13 flag wins", v, 32'hB);
        rd(A_CNT, v); check("R13 count zero", v, 0);

        done = 1;
        report();
        $finish;
    end
endmodule